// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Bank with Bit-Operation Aliases

This block holds the software-visible state of a 16-pin general-purpose I/O port behind a simple memory-mapped bus. The bus has an address, write data, a write strobe, a read strobe and an access size, and it returns read data and an error flag. The bank stores the following words:

- the pin data word
- two interrupt mask words, A and B
- five per-pin configuration words: direction, polarity, edge select, both-edge select and input enable

The data word and both mask words each have three extra write addresses. A write to one of these clears, sets or inverts only the bits that are 1 in the written value. A read from any of these three addresses returns the word they act on. The bank drives each output pin from its data bit wherever that pin is set as an output. For one cycle after a write, it flags the output pins whose level changed.

A separate detection block samples the input pins and computes per-pin pending interrupt requests. That block receives the configuration words from this bank and sends two things back:

- sampled levels, which this bank loads into the data word for input-enabled input pins
- the pending requests, which this bank gates through the two mask words to form two interrupt outputs

Top module: `gpio_bank`

## Requirements
- R1: After reset every stored word is zero. Reads of all mapped offsets return 0, and pin_out, pin_chg, bus_err, irq_a, irq_b and all configuration outputs are 0.
- R2: Registers sit 4 bytes apart and the register index is offset/4. The offsets are 0x00 data, 0x10 mask A, 0x20 mask B, 0x30 direction, 0x34 polarity, 0x38 edge select, 0x3C both-edge select and 0x40 input enable. A legal write to one of these offsets replaces the word, and a later read there returns it.
- R3: A write to base+4 of the data, mask A or mask B group clears each bit of that word where the written value is 1. All other bits are kept.
- R4: A write to base+8 of a group ORs the written value into that group's word.
- R5: A write to base+12 of a group XORs the written value into that group's word.
- R6: A read at base, base+4, base+8 or base+12 of a group returns that group's current word.
- R7: Only bus_size = 1 (16-bit) is legal; 0 (8-bit), 2 (32-bit) and 3 are not. An access of any other size raises bus_err, returns read data 0 and changes no word.
- R8: An access to an offset that is not a multiple of 4, or that lies above 0x40, raises bus_err and changes no word. bus_err and bus_rdata appear in the cycle after the strobe and last one cycle.
- R9: pin_out equals the data word ANDed with the direction word.
- R10: In the cycle after a legal write to the data group or to the direction word, pin_chg has a 1 for exactly those pins whose new direction bit is 1 and whose data bit changed. pin_chg is 0 at all other times.
- R11: irq_a is the OR over pins of irq_pend AND mask A, and irq_b is the same with mask B. Both therefore follow a mask write in the next cycle.
- R12: When smp_stb is 1 for a pin, the pin's sampled level is loaded into its data bit, but only if its direction bit is 0 and its input-enable bit is 1. Otherwise the strobe has no effect. A legal bus write to the data group in the same cycle takes precedence over every sampled level.
- R13: cfg_dir, cfg_pol, cfg_edge, cfg_both, cfg_inen, mask_a and mask_b present the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| bus_err | output | 1 | Error response, the cycle after a rejected access |
| smp_stb | input | 16 | Per-pin strobe from the sampling block |
| smp_lvl | input | 16 | Per-pin sampled level |
| irq_pend | input | 16 | Per-pin pending request from the detection block |
| pin_out | output | 16 | Output pin drive |
| pin_chg | output | 16 | Output pins changed by the last write |
| cfg_dir | output | 16 | Direction word, 1 means output |
| cfg_pol | output | 16 | Polarity word |
| cfg_edge | output | 16 | Edge-select word |
| cfg_both | output | 16 | Both-edge word |
| cfg_inen | output | 16 | Input-enable word |
| mask_a | output | 16 | Interrupt mask A |
| mask_b | output | 16 | Interrupt mask B |
| irq_a | output | 1 | Masked interrupt A |
| irq_b | output | 1 | Masked interrupt B |

## Verification
The bench sweeps every byte offset from 0 to 255. This catches a decoder that aliases unmapped or misaligned offsets onto real registers: such a design would return data instead of an error, or would corrupt a word on a stray write. Each alias operation on each group is run with several bit patterns, and all four addresses of the group are read back after each one. A design that applies the operation to the wrong word, or that treats a clear as a plain write, shows a mismatch at once.

The change flags are checked for a write that keeps data but changes direction, where a correct design flags nothing. Sampled levels are driven at all pins, with direction and input enable mixed, and also in the same cycle as a bus write to the data word. This exposes a design that lets output pins or disabled inputs be overwritten, or that lets a sample defeat the write.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPIN = 16,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [1:0]      bus_size,
  output logic [NPIN-1:0] bus_rdata,
  output logic            bus_err,
  input  logic [NPIN-1:0] smp_stb,
  input  logic [NPIN-1:0] smp_lvl,
  input  logic [NPIN-1:0] irq_pend,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_chg,
  output logic [NPIN-1:0] cfg_dir,
  output logic [NPIN-1:0] cfg_pol,
  output logic [NPIN-1:0] cfg_edge,
  output logic [NPIN-1:0] cfg_both,
  output logic [NPIN-1:0] cfg_inen,
  output logic [NPIN-1:0] mask_a,
  output logic [NPIN-1:0] mask_b,
  output logic            irq_a,
  output logic            irq_b
);

  localparam int NREG   = 17;
  localparam int NALIAS = 12;
  localparam logic [AW-1:0] LAST_A    = AW'((NREG - 1) * 4);
  localparam logic [AW-3:0] ALIAS_END = (AW-2)'(NALIAS);
  localparam logic [1:0]    SZ_HALF   = 2'd1;

  logic [NPIN-1:0] data_q, ma_q, mb_q, dir_q, pol_q, edg_q, both_q, inen_q;
  logic [NPIN-1:0] data_nxt, dir_nxt, smp_ok, rd_mux;
  logic [AW-3:0]   idx;
  logic [1:0]      op, grp;
  logic [2:0]      csel;
  logic            bad, wr_ok, in_alias;
  logic            wr_data, wr_ma, wr_mb, wr_cfg, wr_dir;

  function automatic logic [NPIN-1:0] apply_op(input logic [1:0] o,
                                               input logic [NPIN-1:0] cur,
                                               input logic [NPIN-1:0] w);
    case (o)
      2'd0:    apply_op = w;
      2'd1:    apply_op = cur & ~w;
      2'd2:    apply_op = cur | w;
      default: apply_op = cur ^ w;
    endcase
  endfunction

  assign idx      = bus_addr[AW-1:2];
  assign op       = idx[1:0];
  assign grp      = idx[3:2];
  assign csel     = 3'(idx - ALIAS_END);
  assign bad      = (bus_size != SZ_HALF) || (bus_addr[1:0] != 2'b00) || (bus_addr > LAST_A);
  assign wr_ok    = bus_wr && !bad;
  assign in_alias = idx < ALIAS_END;
  assign wr_data  = wr_ok && in_alias && grp == 2'd0;
  assign wr_ma    = wr_ok && in_alias && grp == 2'd1;
  assign wr_mb    = wr_ok && in_alias && grp == 2'd2;
  assign wr_cfg   = wr_ok && !in_alias;
  assign wr_dir   = wr_cfg && csel == 3'd0;

  assign smp_ok  = smp_stb & ~dir_q & inen_q;
  assign dir_nxt = wr_dir ? bus_wdata : dir_q;

  always_comb begin
    data_nxt = (data_q & ~smp_ok) | (smp_lvl & smp_ok);
    if (wr_data) data_nxt = apply_op(op, data_q, bus_wdata);
  end

  always_comb begin
    if (in_alias) begin
      case (grp)
        2'd0:    rd_mux = data_q;
        2'd1:    rd_mux = ma_q;
        default: rd_mux = mb_q;
      endcase
    end else begin
      case (csel)
        3'd0:    rd_mux = dir_q;
        3'd1:    rd_mux = pol_q;
        3'd2:    rd_mux = edg_q;
        3'd3:    rd_mux = both_q;
        default: rd_mux = inen_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      ma_q      <= '0;
      mb_q      <= '0;
      dir_q     <= '0;
      pol_q     <= '0;
      edg_q     <= '0;
      both_q    <= '0;
      inen_q    <= '0;
      pin_chg   <= '0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      data_q <= data_nxt;
      dir_q  <= dir_nxt;
      if (wr_ma) ma_q <= apply_op(op, ma_q, bus_wdata);
      if (wr_mb) mb_q <= apply_op(op, mb_q, bus_wdata);
      if (wr_cfg) begin
        case (csel)
          3'd1:    pol_q  <= bus_wdata;
          3'd2:    edg_q  <= bus_wdata;
          3'd3:    both_q <= bus_wdata;
          3'd4:    inen_q <= bus_wdata;
          default: ;
        endcase
      end
      pin_chg   <= (wr_data || wr_dir) ? ((data_nxt ^ data_q) & dir_nxt) : '0;
      bus_err   <= (bus_wr || bus_rd) && bad;
      bus_rdata <= (bus_rd && !bad) ? rd_mux : '0;
    end
  end

  assign pin_out  = data_q & dir_q;
  assign cfg_dir  = dir_q;
  assign cfg_pol  = pol_q;
  assign cfg_edge = edg_q;
  assign cfg_both = both_q;
  assign cfg_inen = inen_q;
  assign mask_a   = ma_q;
  assign mask_b   = mb_q;
  assign irq_a    = |(irq_pend & ma_q);
  assign irq_b    = |(irq_pend & mb_q);

  // R7 R8
  bad_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bad) |-> (ma_q == $past(ma_q) && mb_q == $past(mb_q) &&
                              dir_q == $past(dir_q) && inen_q == $past(inen_q)));

  // R8
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_wr || bus_rd));

  // R3
  clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ma && op == 2'd1) |-> (ma_q & $past(bus_wdata)) == '0);

  // R4
  set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_data && op == 2'd2) |-> (data_q & $past(bus_wdata)) == $past(bus_wdata));

  // R10
  chg_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_chg & ~dir_q) == '0);

  // R10
  chg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_chg != '0) |-> $past(bus_wr));

endmodule

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_size = 2'd1;
  logic [15:0] bus_rdata;
  logic        bus_err;
  logic [15:0] smp_stb = '0, smp_lvl = '0, irq_pend = '0;
  logic [15:0] pin_out, pin_chg, cfg_dir, cfg_pol, cfg_edge, cfg_both, cfg_inen, mask_a, mask_b;
  logic        irq_a, irq_b;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] m_w [3];
  logic [15:0] m_c [5];

  always #5 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk, .rst_n, .bus_addr, .bus_wdata, .bus_wr, .bus_rd, .bus_size,
    .bus_rdata, .bus_err, .smp_stb, .smp_lvl, .irq_pend, .pin_out, .pin_chg,
    .cfg_dir, .cfg_pol, .cfg_edge, .cfg_both, .cfg_inen, .mask_a, .mask_b,
    .irq_a, .irq_b);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'((i + 1) * 40503) ^ 16'(i << 7);
  endfunction

  task automatic bw(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sz);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_size = 2'd1;
  endtask

  task automatic br(input logic [7:0] a, input logic [1:0] sz, output logic [15:0] rd, output logic e);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_size = 2'd1;
    rd = bus_rdata; e = bus_err;
  endtask

  function automatic logic [15:0] model_op(input int o, input logic [15:0] c, input logic [15:0] w);
    case (o)
      0: return w;
      1: return c & ~w;
      2: return c | w;
      default: return c ^ w;
    endcase
  endfunction

  task automatic check_all(input string req);
    logic [15:0] rd; logic e;
    for (int g = 0; g < 3; g++) begin
      br(8'(g * 16), 2'd1, rd, e);
      chk(req, rd, m_w[g]);
    end
    for (int c = 0; c < 5; c++) begin
      br(8'(48 + c * 4), 2'd1, rd, e);
      chk(req, rd, m_c[c]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd, exp, old;
    logic e;
    for (int i = 0; i < 3; i++) m_w[i] = '0;
    for (int i = 0; i < 5; i++) m_c[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 outputs", {pin_out, pin_chg}, 32'h0);
    chk("R1 flags", {29'h0, bus_err, irq_a, irq_b}, 32'h0);
    chk("R1 cfg", {cfg_dir | cfg_pol | cfg_edge | cfg_both, cfg_inen | mask_a | mask_b}, 32'h0);
    check_all("R1 reset read");

    // R2 R13 R9: configuration words
    for (int c = 0; c < 5; c++) begin
      m_c[c] = pat(c + 40);
      bw(8'(48 + c * 4), m_c[c], 2'd1);
    end
    check_all("R2 cfg readback");
    chk("R13 cfg ports", {cfg_dir, cfg_pol}, {m_c[0], m_c[1]});
    chk("R13 cfg ports", {cfg_edge, cfg_both}, {m_c[2], m_c[3]});
    chk("R13 cfg ports", {16'h0, cfg_inen}, {16'h0, m_c[4]});

    // R2..R6 R9 R10 R11 R13: alias sweep
    irq_pend = 16'h0204;
    for (int g = 0; g < 3; g++)
      for (int o = 0; o < 4; o++)
        for (int k = 0; k < 6; k++) begin
          old = m_w[g];
          m_w[g] = model_op(o, old, pat(g * 31 + o * 7 + k));
          bw(8'(g * 16 + o * 4), pat(g * 31 + o * 7 + k), 2'd1);
          if (g == 0) begin
            // R10
            chk("R10 change flags", pin_chg, (old ^ m_w[0]) & m_c[0]);
            // R9
            chk("R9 pin drive", pin_out, m_w[0] & m_c[0]);
          end
          // R11
          chk("R11 irq", {30'h0, irq_a, irq_b}, {30'h0, |(irq_pend & m_w[1]), |(irq_pend & m_w[2])});
          chk("R13 masks", {mask_a, mask_b}, {m_w[1], m_w[2]});
          for (int al = 0; al < 4; al++) begin
            br(8'(g * 16 + al * 4), 2'd1, rd, e);
            // R3 R4 R5 R6
            chk(o == 1 ? "R3 clear alias" : o == 2 ? "R4 set alias" : o == 3 ? "R5 toggle alias" : "R6 alias read",
                {15'h0, e, rd}, {16'h0, m_w[g]});
          end
          chk("R10 flag lasts one cycle", pin_chg, 16'h0);
        end

    // R10: direction write flags pins with new dir=1 whose data changed (none)
    m_c[0] = ~m_c[0];
    bw(8'h30, m_c[0], 2'd1);
    chk("R10 dir write no data change", pin_chg, 16'h0);
    chk("R9 pin drive after dir", pin_out, m_w[0] & m_c[0]);

    // R8: sweep all offsets for read errors
    for (int a = 0; a < 256; a++) begin
      br(8'(a), 2'd1, rd, e);
      if ((a % 4) != 0 || a > 64) chk("R8 unmapped read", {15'h0, e, rd}, {15'h0, 1'b1, 16'h0});
      else chk("R8 mapped read", {31'h0, e}, 32'h0);
    end
    // R8: bad writes change nothing
    bw(8'h44, 16'hFFFF, 2'd1);
    chk("R8 write error", {31'h0, bus_err}, 32'h1);
    bw(8'h02, 16'hFFFF, 2'd1);
    chk("R8 write error", {31'h0, bus_err}, 32'h1);
    bw(8'h11, 16'hFFFF, 2'd1);
    @(negedge clk);
    chk("R8 error one cycle", {31'h0, bus_err}, 32'h0);
    check_all("R8 no change");

    // R7: wrong sizes
    for (int s = 0; s < 4; s++) begin
      if (s == 1) continue;
      bw(8'h08, 16'hFFFF, 2'(s));
      chk("R7 size write error", {31'h0, bus_err}, 32'h1);
      bw(8'h40, 16'hA5A5, 2'(s));
      br(8'h00, 2'(s), rd, e);
      chk("R7 size read error", {15'h0, e, rd}, {15'h0, 1'b1, 16'h0});
    end
    check_all("R7 no change");

    // R12: sampled levels
    m_c[0] = 16'h00FF; bw(8'h30, m_c[0], 2'd1);
    m_c[4] = 16'h0F0F; bw(8'h40, m_c[4], 2'd1);
    m_w[0] = 16'h1234; bw(8'h00, m_w[0], 2'd1);
    @(negedge clk);
    smp_stb = 16'hFFFF; smp_lvl = 16'hC3C3;
    @(negedge clk);
    smp_stb = '0;
    exp = (m_w[0] & ~16'h0F00) | (16'hC3C3 & 16'h0F00);
    m_w[0] = exp;
    br(8'h00, 2'd1, rd, e);
    chk("R12 sample load", rd, exp);
    smp_stb = 16'h00F0; smp_lvl = 16'hFFFF;
    @(negedge clk);
    smp_stb = '0;
    br(8'h00, 2'd1, rd, e);
    chk("R12 sample ignored", rd, exp);
    // same-cycle bus write wins
    @(negedge clk);
    smp_stb = 16'hFFFF; smp_lvl = 16'h0000;
    bus_addr = 8'h08; bus_wdata = 16'h0F00; bus_size = 2'd1; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; smp_stb = '0;
    m_w[0] = exp | 16'h0F00;
    br(8'h00, 2'd1, rd, e);
    chk("R12 bus write precedence", rd, m_w[0]);
    chk("R9 pin drive", pin_out, m_w[0] & m_c[0]);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule